// File: doc/BRIEF.md
# Paired Timer Output-Compare Reference Generator

This block turns a running timer count into active-high reference waveforms for two compare channels. Each channel holds its own compare value and a 4-bit mode. The mode selects one of the following behaviours:
- hold the level;
- set, clear or invert the level on an equal match;
- drive a constant;
- produce edge- or centre-aligned PWM in either sense;
- act as a retriggerable one-pulse output.

A third output mixes the two channel references. It gives their OR or their AND, or it picks one channel or the other by counting direction. This lets two compare values shape one waveform.

The timer counter, capture, dead-time and output polarity sit elsewhere. Software programs the modes through one 32-bit write port and the compare values through a per-channel write strobe. Every reference is a flop that updates on the clock edge after the count is presented.

Top module: `tim_oc_pair`

## Requirements
- R1: After reset, all three outputs are 0 and both modes are 0000 with compare values 0. A mode write takes channel A's mode as {wdata[16], wdata[6:4]} and channel B's mode as {wdata[24], wdata[14:12]}. All other write bits are ignored.
- R2: In modes 0000, 1010 and 1011 a channel's reference keeps its previous level.
- R3: Mode 0001 sets the reference to 1 on a cycle where count equals the compare value. Mode 0010 sets it to 0 on such a cycle. On any other cycle the level is held.
- R4: Mode 0011 inverts the reference on each cycle with count equal to the compare value.
- R5: Mode 0100 drives the reference to 0 and mode 0101 drives it to 1, whatever the count.
- R6: The PWM level is computed as follows:
  - When counting up (cnt_down=0), it is 1 while count < compare.
  - When counting down, it is 1 while count <= compare.
  - Modes 0110, 1100 and 1110 use this level.
  - Modes 0111, 1101 and 1111 use its inverse.
- R7: In a PWM mode, the reference takes the PWM level only when that level differs from the previous cycle's level, or when the previous cycle's mode was frozen (R2). Otherwise it holds.
- R8: With channel A in mode 1100 the mix output is A OR B. With channel A in mode 1101 it is A AND B.
- R9: With channel A in mode 1110 or 1111, the mix output is the channel A reference when the direction registered with the references was up, and the channel B reference when it was down. In any mode other than those of R8 and R9, the mix output equals the channel A reference.
- R10: Each channel keeps a pulse flag. A trigger sets the flag. A compare equality clears it, but the trigger wins when both fall in the same cycle.
  - Mode 1000 outputs the next flag value when counting up and its inverse when counting down.
  - Mode 1001 outputs the opposite of mode 1000.
- R11: Every reference reflects the count, direction and trigger of the cycle before. A mode or compare write applies from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CW | Current timer count |
| cnt_down | input | 1 | 1 while the timer counts down |
| trig | input | 1 | Trigger event pulse for one-pulse mode |
| mode_we | input | 1 | Write strobe for both mode fields |
| mode_wdata | input | 32 | Mode register write data |
| cmp_we | input | 2 | Compare write strobes, bit 0 channel A, bit 1 channel B |
| cmp_wdata | input | CW | Compare value to write |
| ref_a | output | 1 | Channel A reference |
| ref_b | output | 1 | Channel B reference |
| ref_mix | output | 1 | Combined reference of A and B |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a trigger and a compare equality in one-pulse mode. The sweep raises the trigger exactly when the count equals channel A's compare value, and the expected output says the pulse flag stays set.

The second pair is entry into PWM from frozen and an unchanged comparison result. Every mode pair is swept in a row, so frozen-to-PWM and other-to-PWM transitions both occur. The bench model judges, cycle by cycle, whether the level must load or hold.

// File: rtl/tim_oc_pair.sv
module tim_oc_pair #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_down,
  input  logic          trig,
  input  logic          mode_we,
  input  logic [31:0]   mode_wdata,
  input  logic [1:0]    cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output logic          ref_a,
  output logic          ref_b,
  output logic          ref_mix
);

  logic [3:0]    mode_q [2];
  logic [CW-1:0] cmp_q  [2];
  logic [1:0] ref_q, lvl_q, frz_q, hit_q;
  logic [1:0] eq, lvl, hit_n, frz, ref_n;
  logic       dn_q;

  logic [3:0] mode_wr [2];
  assign mode_wr[0] = {mode_wdata[16], mode_wdata[6:4]};
  assign mode_wr[1] = {mode_wdata[24], mode_wdata[14:12]};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      eq[i]    = (cnt == cmp_q[i]);
      lvl[i]   = cnt_down ? (cnt <= cmp_q[i]) : (cnt < cmp_q[i]);
      hit_n[i] = trig | (hit_q[i] & ~eq[i]);
      frz[i]   = (mode_q[i] == 4'd0) || (mode_q[i] == 4'd10) || (mode_q[i] == 4'd11);
      case (mode_q[i])
        4'd1:                ref_n[i] = eq[i] ? 1'b1 : ref_q[i];
        4'd2:                ref_n[i] = eq[i] ? 1'b0 : ref_q[i];
        4'd3:                ref_n[i] = eq[i] ^ ref_q[i];
        4'd4:                ref_n[i] = 1'b0;
        4'd5:                ref_n[i] = 1'b1;
        4'd6, 4'd12, 4'd14:  ref_n[i] = (lvl[i] != lvl_q[i] || frz_q[i]) ? lvl[i] : ref_q[i];
        4'd7, 4'd13, 4'd15:  ref_n[i] = (lvl[i] != lvl_q[i] || frz_q[i]) ? ~lvl[i] : ref_q[i];
        4'd8:                ref_n[i] = hit_n[i] ^ cnt_down;
        4'd9:                ref_n[i] = ~(hit_n[i] ^ cnt_down);
        default:             ref_n[i] = ref_q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        mode_q[i] <= '0;
        cmp_q[i]  <= '0;
      end
      ref_q <= '0;
      lvl_q <= '0;
      frz_q <= 2'b11;
      hit_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      ref_q <= ref_n;
      lvl_q <= lvl;
      frz_q <= frz;
      hit_q <= hit_n;
      dn_q  <= cnt_down;
      for (int i = 0; i < 2; i++) begin
        if (mode_we)   mode_q[i] <= mode_wr[i];
        if (cmp_we[i]) cmp_q[i]  <= cmp_wdata;
      end
    end
  end

  assign ref_a = ref_q[0];
  assign ref_b = ref_q[1];

  always_comb begin
    case (mode_q[0])
      4'd12:        ref_mix = ref_q[0] | ref_q[1];
      4'd13:        ref_mix = ref_q[0] & ref_q[1];
      4'd14, 4'd15: ref_mix = dn_q ? ref_q[1] : ref_q[0];
      default:      ref_mix = ref_q[0];
    endcase
  end

  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == 4'd0) |=> $stable(ref_a));

  p_match_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == 4'd1 && cnt == cmp_q[0]) |=> ref_a);

  p_match_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] == 4'd2 && cnt == cmp_q[1]) |=> !ref_b);

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == 4'd3 && cnt == cmp_q[0]) |=> (ref_a != $past(ref_a)));

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == 4'd4) |=> !ref_a);

  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] == 4'd5) |=> ref_b);

  p_opm_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == 4'd8 && trig && !cnt_down) |=> ref_a);

endmodule

// File: tb/sim_tim_oc_pair.sv
module sim_tim_oc_pair;
  localparam int CW  = 4;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic cnt_down = 1'b0, trig = 1'b0, mode_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic [1:0] cmp_we = '0;
  logic [CW-1:0] cmp_wdata = '0;
  logic ref_a, ref_b, ref_mix;

  int total = 0, bad = 0;
  logic [3:0] nm [2];

  logic [3:0] bm [2];
  logic [CW-1:0] bc [2];
  logic [1:0] br, bl, bf, bh;
  logic bdq;

  always #(PER/2) clk = ~clk;

  tim_oc_pair #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down), .trig(trig),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .ref_a(ref_a), .ref_b(ref_b), .ref_mix(ref_mix));

  always @(posedge clk) begin
    if (!rst_n) begin
      bm[0] <= '0; bm[1] <= '0; bc[0] <= '0; bc[1] <= '0;
      br <= '0; bl <= '0; bf <= 2'b11; bh <= '0; bdq <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic e, l, h, r, z;
        int m;
        m = int'(bm[i]);
        e = (int'(cnt) == int'(bc[i]));
        l = cnt_down ? (int'(cnt) <= int'(bc[i])) : (int'(cnt) < int'(bc[i]));
        h = trig ? 1'b1 : (e ? 1'b0 : bh[i]);
        r = br[i];
        z = (l != bl[i]) || bf[i];
        case (m)
          1: r = e ? 1'b1 : r;
          2: r = e ? 1'b0 : r;
          3: r = e ? !r : r;
          4: r = 1'b0;
          5: r = 1'b1;
          6, 12, 14: r = z ? l : r;
          7, 13, 15: r = z ? !l : r;
          8: r = cnt_down ? !h : h;
          9: r = cnt_down ? h : !h;
          default: r = r;
        endcase
        br[i] <= r;
        bl[i] <= l;
        bh[i] <= h;
        bf[i] <= (m == 0 || m == 10 || m == 11);
        if (mode_we)   bm[i] <= nm[i];
        if (cmp_we[i]) bc[i] <= cmp_wdata;
      end
      bdq <= cnt_down;
    end
  end

  function automatic logic exp_mix();
    case (int'(bm[0]))
      12: return br[0] | br[1];
      13: return br[0] & br[1];
      14, 15: return bdq ? br[1] : br[0];
      default: return br[0];
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      1, 2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7, 12, 13, 14, 15: return "R6/R7";
      8, 9: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic string mix_tag(int m);
    if (m == 12 || m == 13) return "R8";
    if (m == 14 || m == 15) return "R9";
    return "R11";
  endfunction

  task automatic chk(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(int'(bm[0])), ref_a, br[0]);
    chk(tag_of(int'(bm[1])), ref_b, br[1]);
    chk(mix_tag(int'(bm[0])), ref_mix, exp_mix());
    mode_we = 1'b0; cmp_we = '0; trig = 1'b0;
  endtask

  initial begin
    #(PER * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    nm[0] = '0; nm[1] = '0;
    repeat (3) @(negedge clk);
    chk("R1", ref_a, 1'b0);
    chk("R1", ref_b, 1'b0);
    chk("R1", ref_mix, 1'b0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int c1, c2;
        c1 = (a * 3 + b) % 16;
        c2 = (b * 5 + 1) % 16;
        cmp_we = 2'b01; cmp_wdata = CW'(c1); tick();
        cmp_we = 2'b10; cmp_wdata = CW'(c2); tick();
        nm[0] = 4'(a); nm[1] = 4'(b);
        mode_wdata = (32'hA5A5_A5A5 & ~32'h0101_7070)
                   | (32'(a & 7) << 4) | (32'((a >> 3) & 1) << 16)
                   | (32'(b & 7) << 12) | (32'((b >> 3) & 1) << 24);
        mode_we = 1'b1;
        tick();
        for (int k = 0; k < 16; k++) begin
          cnt = CW'(k); cnt_down = 1'b0;
          trig = (k == c1) || (k == 3);
          tick();
        end
        for (int k = 15; k >= 0; k--) begin
          cnt = CW'(k); cnt_down = 1'b1;
          trig = (k == 9);
          tick();
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule